// File: doc/BRIEF.md
# Paired-Halfword Dot-Product Engine

This block computes the dot product of two vectors of signed 16-bit samples that are stored two per 32-bit word in two separate operand memories. A run starts with a one-cycle start pulse and a sample count. The engine then reads one word from each memory per cycle. A low lane multiplies the two low halfwords and a high lane multiplies the two high halfwords in the same cycle. Each lane keeps its own running sum, and the two sums are added once the last word pair has gone through the pipeline.

The pipeline has fixed depths and a new word pair enters every cycle. A read issued in a given cycle reaches the multipliers five cycles later. A product reaches its accumulator two cycles after the multiply. The final sum is presented one cycle after the last accumulation. For N samples, the cycles from the first read through the done pulse number 7 + N/2 + 1. A separate halfword multiplier is also provided. It takes two 32-bit words and a half selector and multiplies the selected signed halves.

Top module: `dotpair_engine`

## Requirements
- R1: In each operand word, bits [15:0] hold one signed two's-complement sample and bits [31:16] hold the next one. `result` equals the sum, over all word addresses read, of low(a)·low(b) plus high(a)·high(b). The low-half products and the high-half products are accumulated in separate sums that are added at the end.
- R2: A start accepted at clock edge 0 with an even, non-zero `count` = N drives `a_rd` and `b_rd` high in cycles 1 through N/2 after that edge, with `a_addr` = `b_addr` = 0, 1, …, N/2−1 in those cycles. The memories return the addressed word at the next edge (one-cycle read latency).
- R3: For a valid run, `done` is high for exactly one cycle, in cycle N/2 + 8 after the accepting edge, with `result` valid. `result` holds its value while the engine stays idle until the next accepted start.
- R4: Both lane sums and the final sum are 32 bits wide and wrap modulo 2^32.
- R5: `ovf` is sticky. It is set when either lane sum or the final sum overflows in signed 32-bit arithmetic, and it is visible in the `done` cycle. An accepted start clears it.
- R6: A start with `count` odd or zero is rejected. `done` and `len_err` are high in cycle 1, no read is issued, and `result` is 0. `len_err` stays high until the next accepted start with a valid count clears it.
- R7: A start asserted while a run is in progress is ignored. The run's addresses, done timing and result are unchanged.
- R8: The halfword multiplier returns the signed 32-bit product one cycle after its inputs are sampled. `hm_sel` selects the halves: 0 = low(a)·low(b), 1 = high(a)·high(b), 2 = low(a)·high(b), 3 = high(a)·low(b).
- R9: A start in the cycle right after `done` is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start request, sampled while idle |
| count | input | AW+1 | Number of samples per vector |
| a_rd | output | 1 | Read strobe for operand memory A |
| a_addr | output | AW | Word address for memory A |
| a_data | input | 32 | Word returned by memory A one cycle after the read |
| b_rd | output | 1 | Read strobe for operand memory B |
| b_addr | output | AW | Word address for memory B |
| b_data | input | 32 | Word returned by memory B one cycle after the read |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Dot product (the sum of both lanes) |
| ovf | output | 1 | Sticky signed-overflow flag |
| len_err | output | 1 | Rejected-count flag |
| hm_a | input | 32 | Halfword multiplier operand A |
| hm_b | input | 32 | Halfword multiplier operand B |
| hm_sel | input | 2 | Half selection code |
| hm_prod | output | 32 | Halfword product, registered |

## Verification
If a tag in the valid/last pipeline is lost or misaligned, `done` moves away from cycle N/2 + 8. A misaligned tag can also drop the last product or add a stale one. Either effect shows up at the ports within the same run. An address counter that skips or stalls shows up at `a_addr` in the very next cycle, and the per-cycle comparison catches it. A lane that swaps halves or picks up data from the wrong delay stage changes `result` in the `done` cycle. Sticky-flag faults are covered by patterns that overflow a lane, patterns that overflow only the final sum, and clean runs that follow an overflow.

// File: rtl/dpe_pkg.sv
package dpe_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2,
        ST_ERR  = 2'd3
    } dpe_state_e;

    typedef enum logic [1:0] {
        HS_LL = 2'd0,
        HS_HH = 2'd1,
        HS_LH = 2'd2,
        HS_HL = 2'd3
    } half_sel_e;

    // Two samples carried in one 32-bit word; the later sample sits on top.
    typedef struct packed {
        logic [15:0] hi;
        logic [15:0] lo;
    } pair_t;

    // Pipeline tag travelling beside the data.
    typedef struct packed {
        logic v;
        logic last;
    } tag_t;

    function automatic logic [31:0] mul16(input logic [15:0] x, input logic [15:0] y);
        logic signed [31:0] xe;
        logic signed [31:0] ye;
        xe = 32'(signed'(x));
        ye = 32'(signed'(y));
        return 32'(xe * ye);
    endfunction

    function automatic logic add_ovf(input logic [31:0] a, input logic [31:0] b,
                                     input logic [31:0] s);
        return (a[31] == b[31]) && (s[31] != a[31]);
    endfunction

endpackage

// File: rtl/dpe_ctrl.sv
module dpe_ctrl
    import dpe_pkg::*;
#(
    parameter int AW    = 8,
    parameter int DEPTH = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW:0]   count,
    output logic          busy,
    output logic          clr,
    output logic          rd,
    output logic [AW-1:0] addr,
    output logic          acc_en,
    output logic          fin,
    output logic          done,
    output logic          len_err
);
    dpe_state_e    st;
    logic [AW-1:0] left;
    logic          issue;
    logic          last_issue;
    logic          bad;
    tag_t          tag_q [DEPTH];

    always_comb begin
        bad        = (count == '0) || count[0];
        clr        = start && (st == ST_IDLE);
        issue      = (st == ST_RUN) && (left != '0);
        last_issue = issue && (left == AW'(1));
        busy       = (st != ST_IDLE);
        rd         = issue;
        fin        = (st == ST_FIN);
        done       = (st == ST_FIN) || (st == ST_ERR);
        acc_en     = tag_q[DEPTH-1].v;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) tag_q[i] <= '0;
        end else begin
            tag_q[0] <= '{v: issue, last: last_issue};
            for (int i = 1; i < DEPTH; i++) tag_q[i] <= tag_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            left    <= '0;
            addr    <= '0;
            len_err <= 1'b0;
        end else begin
            unique case (st)
                ST_IDLE: if (clr) begin
                    if (bad) begin
                        st      <= ST_ERR;
                        len_err <= 1'b1;
                    end else begin
                        st      <= ST_RUN;
                        left    <= count[AW:1];
                        addr    <= '0;
                        len_err <= 1'b0;
                    end
                end
                ST_RUN: begin
                    if (issue) begin
                        left <= left - AW'(1);
                        addr <= addr + AW'(1);
                    end
                    if (tag_q[DEPTH-1].v && tag_q[DEPTH-1].last) st <= ST_FIN;
                end
                ST_FIN:  st <= ST_IDLE;
                ST_ERR:  st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dpe_lane.sv
module dpe_lane
    import dpe_pkg::*;
#(
    parameter int LOAD_LAT = 5,
    parameter int MUL_LAT  = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        clr,
    input  logic        acc_en,
    input  logic [15:0] a_h,
    input  logic [15:0] b_h,
    output logic [31:0] acc,
    output logic        ovf_evt
);
    // One cycle of the load latency is spent inside the memory itself.
    localparam int OPD = LOAD_LAT - 1;

    logic [15:0] opa [OPD];
    logic [15:0] opb [OPD];
    logic [31:0] pq  [MUL_LAT];
    logic [31:0] p_last;
    logic [31:0] nsum;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < OPD; i++) begin
                opa[i] <= '0;
                opb[i] <= '0;
            end
            for (int i = 0; i < MUL_LAT; i++) pq[i] <= '0;
        end else begin
            opa[0] <= a_h;
            opb[0] <= b_h;
            for (int i = 1; i < OPD; i++) begin
                opa[i] <= opa[i-1];
                opb[i] <= opb[i-1];
            end
            pq[0] <= mul16(opa[OPD-1], opb[OPD-1]);
            for (int i = 1; i < MUL_LAT; i++) pq[i] <= pq[i-1];
        end
    end

    always_comb begin
        p_last  = pq[MUL_LAT-1];
        nsum    = acc + p_last;
        ovf_evt = acc_en && add_ovf(acc, p_last, nsum);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) acc <= '0;
        else if (acc_en) acc <= nsum;
    end
endmodule

// File: rtl/dpe_halfmul.sv
module dpe_halfmul
    import dpe_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] a,
    input  logic [31:0] b,
    input  logic [1:0]  sel,
    output logic [31:0] prod
);
    pair_t       pa;
    pair_t       pb;
    logic [15:0] xa;
    logic [15:0] xb;

    always_comb begin
        pa = pair_t'(a);
        pb = pair_t'(b);
        unique case (half_sel_e'(sel))
            HS_LL: begin xa = pa.lo; xb = pb.lo; end
            HS_HH: begin xa = pa.hi; xb = pb.hi; end
            HS_LH: begin xa = pa.lo; xb = pb.hi; end
            HS_HL: begin xa = pa.hi; xb = pb.lo; end
            default: begin xa = pa.lo; xb = pb.lo; end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) prod <= '0;
        else     prod <= mul16(xa, xb);
    end
endmodule

// File: rtl/dotpair_engine.sv
module dotpair_engine
    import dpe_pkg::*;
#(
    parameter int AW       = 8,
    parameter int LOAD_LAT = 5,
    parameter int MUL_LAT  = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW:0]   count,
    output logic          a_rd,
    output logic [AW-1:0] a_addr,
    input  logic [31:0]   a_data,
    output logic          b_rd,
    output logic [AW-1:0] b_addr,
    input  logic [31:0]   b_data,
    output logic          done,
    output logic [31:0]   result,
    output logic          ovf,
    output logic          len_err,
    input  logic [31:0]   hm_a,
    input  logic [31:0]   hm_b,
    input  logic [1:0]    hm_sel,
    output logic [31:0]   hm_prod
);
    localparam int NLANE = 2;
    localparam int DEPTH = LOAD_LAT + MUL_LAT;

    logic          busy;
    logic          clr;
    logic          rd;
    logic [AW-1:0] addr;
    logic          acc_en;
    logic          fin;
    logic          sum_ovf;
    logic          ovf_q;
    logic [31:0]   lane_acc [NLANE];
    logic [NLANE-1:0] lane_ovf;

    dpe_ctrl #(.AW(AW), .DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst(rst), .start(start), .count(count),
        .busy(busy), .clr(clr), .rd(rd), .addr(addr),
        .acc_en(acc_en), .fin(fin), .done(done), .len_err(len_err)
    );

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        dpe_lane #(.LOAD_LAT(LOAD_LAT), .MUL_LAT(MUL_LAT)) u_lane (
            .clk(clk), .rst(rst), .clr(clr), .acc_en(acc_en),
            .a_h(a_data[16*g +: 16]), .b_h(b_data[16*g +: 16]),
            .acc(lane_acc[g]), .ovf_evt(lane_ovf[g])
        );
    end

    dpe_halfmul u_hm (
        .clk(clk), .rst(rst), .a(hm_a), .b(hm_b), .sel(hm_sel), .prod(hm_prod)
    );

    always_comb begin
        a_rd    = rd;
        b_rd    = rd;
        a_addr  = addr;
        b_addr  = addr;
        result  = lane_acc[0] + lane_acc[1];
        sum_ovf = add_ovf(lane_acc[0], lane_acc[1], result);
        ovf     = ovf_q || (fin && sum_ovf);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) ovf_q <= 1'b0;
        else if ((|lane_ovf) || (fin && sum_ovf)) ovf_q <= 1'b1;
    end
endmodule

// File: rtl/dpe_checker.sv
module dpe_checker #(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          busy,
    input logic [AW:0]   count,
    input logic          a_rd,
    input logic [AW-1:0] a_addr,
    input logic          done,
    input logic          len_err,
    input logic [31:0]   result
);
    assert_done_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_addr_step_R2: assert property (@(posedge clk) disable iff (rst)
        (a_rd && $past(a_rd)) |-> (a_addr == $past(a_addr) + AW'(1)));

    assert_good_start_R2: assert property (@(posedge clk) disable iff (rst)
        (!busy && start && count != '0 && !count[0]) |=> (a_rd && a_addr == '0 && !len_err));

    assert_bad_count_R6: assert property (@(posedge clk) disable iff (rst)
        (!busy && start && (count == '0 || count[0])) |=> (done && len_err && !a_rd));

    assert_idle_no_read_R7: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !a_rd);

    assert_result_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!busy && $past(!busy) && !$past(start)) |-> $stable(result));
endmodule

bind dotpair_engine dpe_checker #(.AW(AW)) u_chk (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .count(count),
    .a_rd(a_rd), .a_addr(a_addr), .done(done), .len_err(len_err), .result(result)
);

// File: tb/sim_dotpair_engine.sv
module sim_dotpair_engine;
    localparam int AW = 8;
    localparam int NW = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [AW:0]   count = '0;
    logic          a_rd, b_rd;
    logic [AW-1:0] a_addr, b_addr;
    logic [31:0]   a_data, b_data;
    logic          done, ovf, len_err;
    logic [31:0]   result;
    logic [31:0]   hm_a = '0, hm_b = '0, hm_prod;
    logic [1:0]    hm_sel = '0;

    logic [31:0] mema [NW];
    logic [31:0] memb [NW];

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    dotpair_engine #(.AW(AW)) u0 (
        .clk(clk), .rst(rst), .start(start), .count(count),
        .a_rd(a_rd), .a_addr(a_addr), .a_data(a_data),
        .b_rd(b_rd), .b_addr(b_addr), .b_data(b_data),
        .done(done), .result(result), .ovf(ovf), .len_err(len_err),
        .hm_a(hm_a), .hm_b(hm_b), .hm_sel(hm_sel), .hm_prod(hm_prod)
    );

    always_ff @(posedge clk) begin
        if (a_rd) a_data <= mema[a_addr];
        if (b_rd) b_data <= memb[b_addr];
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic longint sx(input logic [15:0] h);
        return longint'(signed'(h));
    endfunction

    task automatic run(input int n, input bit poke, input string tag);
        int m;
        int dt;
        bit bad;
        longint sl, sh, tot, p;
        bit eovf;
        logic [31:0] eres;
        m = n / 2;
        bad = (n == 0) || (n % 2 != 0);
        dt = bad ? 1 : m + 8;
        sl = 0; sh = 0; eovf = 0;
        if (!bad) begin
            for (int i = 0; i < m; i++) begin
                p = sx(mema[i][15:0]) * sx(memb[i][15:0]);
                sl = sl + p;
                if (sl > 64'sd2147483647 || sl < -64'sd2147483648) eovf = 1;
                sl = longint'(signed'(sl[31:0]));
                p = sx(mema[i][31:16]) * sx(memb[i][31:16]);
                sh = sh + p;
                if (sh > 64'sd2147483647 || sh < -64'sd2147483648) eovf = 1;
                sh = longint'(signed'(sh[31:0]));
            end
            tot = sl + sh;
            if (tot > 64'sd2147483647 || tot < -64'sd2147483648) eovf = 1;
            eres = tot[31:0];
        end else begin
            eres = '0;
        end
        start = 1'b1;
        count = (AW+1)'(n);
        @(negedge clk);
        start = 1'b0;
        for (int t = 1; t <= dt; t++) begin
            // R2 / R6 / R7: per-cycle comparison against the expected schedule
            if (poke && t == 3) begin start = 1'b1; count = (AW+1)'(6); end
            if (poke && t == 4) start = 1'b0;
            chk(a_rd == (!bad && t <= m) && b_rd == a_rd, {tag, " R2 rd"},
                32'(a_rd), 32'(!bad && t <= m));
            if (!bad && t <= m)
                chk(a_addr == AW'(t-1) && b_addr == a_addr, {tag, " R2 addr"},
                    32'(a_addr), 32'(t-1));
            chk(done == (t == dt), {tag, " R3 done timing"}, 32'(done), 32'(t == dt));
            if (t < dt) @(negedge clk);
        end
        chk(result == eres, {tag, " R1 result"}, result, eres);
        chk(ovf == eovf, {tag, " R5 ovf"}, 32'(ovf), 32'(eovf));
        chk(len_err == bad, {tag, " R6 len_err"}, 32'(len_err), 32'(bad));
        @(negedge clk);
        chk(!done, {tag, " R3 single pulse"}, 32'(done), 32'd0);
        chk(result == eres, {tag, " R3 result hold"}, result, eres);
    endtask

    task automatic hmul(input logic [31:0] x, input logic [31:0] y, input logic [1:0] s);
        longint e;
        logic [15:0] hx, hy;
        hx = (s == 2'd1 || s == 2'd3) ? x[31:16] : x[15:0];
        hy = (s == 2'd1 || s == 2'd2) ? y[31:16] : y[15:0];
        e = sx(hx) * sx(hy);
        hm_a = x; hm_b = y; hm_sel = s;
        @(negedge clk);
        chk(hm_prod == e[31:0], "R8 halfword multiply", hm_prod, e[31:0]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < NW; i++) begin mema[i] = '0; memb[i] = '0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!done && !a_rd && !b_rd && !ovf && !len_err && result == '0,
            "reset state", {28'd0, done, a_rd, ovf, len_err}, 32'd0);

        // R1: small hand-worked case, (-4*7) + (3*-5) = -43
        mema[0] = {16'sd3, -16'sd4};
        memb[0] = {-16'sd5, 16'sd7};
        run(2, 1'b0, "n2");
        chk(result == 32'hFFFF_FFD5, "R1 known value", result, 32'hFFFF_FFD5);

        // R1/R2/R3: long random run
        for (int i = 0; i < 100; i++) begin mema[i] = $urandom; memb[i] = $urandom; end
        run(200, 1'b0, "n200");

        // R4/R5: lane overflow with wrap back to zero
        for (int i = 0; i < 4; i++) begin mema[i] = 32'h8000_8000; memb[i] = 32'h8000_8000; end
        run(8, 1'b0, "lane_wrap R4");

        // R5: lane sums fine, only the final add overflows
        mema[0] = 32'h8000_8000; memb[0] = 32'h8000_8000;
        mema[1] = '0; memb[1] = '0;
        run(4, 1'b0, "final_ovf R5");

        // R9 and R5 clear: start right in the cycle after done
        for (int i = 0; i < 3; i++) begin mema[i] = {16'sd100, 16'sd2}; memb[i] = {16'sd1, -16'sd3}; end
        run(6, 1'b0, "b2b R9");

        // R6: rejected counts
        run(7, 1'b0, "odd R6");
        run(0, 1'b0, "zero R6");
        run(10, 1'b0, "after_err R6");

        // R7: start pulse during a run is ignored
        for (int i = 0; i < 10; i++) begin mema[i] = $urandom; memb[i] = $urandom; end
        run(20, 1'b1, "busy R7");
        chk(!a_rd && !done, "R7 no extra run", {30'd0, a_rd, done}, 32'd0);

        // R8: four half selections
        hmul({-16'sd2, 16'sd300}, {16'sd7, -16'sd5}, 2'd0);
        hmul({-16'sd2, 16'sd300}, {16'sd7, -16'sd5}, 2'd1);
        hmul({-16'sd2, 16'sd300}, {16'sd7, -16'sd5}, 2'd2);
        hmul({-16'sd2, 16'sd300}, {16'sd7, -16'sd5}, 2'd3);
        hmul(32'h8000_7FFF, 32'h8000_7FFF, 2'd1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule